// File: doc/BRIEF.md
# VGA 640x480 Raster Timing and Moving-Stripe Generator

This block produces the raster timing for a 640x480 display running from a 25 MHz pixel clock. Two free-running counters walk every pixel clock of an 800-clock line and every line of a 521-line frame. From these counters the block derives the active-low horizontal and vertical sync pulses, a flag that marks the visible area, and the current column and row. The line is 32 µs long and the refresh rate is close to 60 Hz.

A pattern source built into the block draws vertical coloured stripes on an 8-bit colour bus. The bus carries red in bits 7:5, green in bits 4:2 and blue in bits 1:0. The stripe index is the column plus an offset that grows by one each frame, so the stripes drift across the screen. All outputs come from one register stage, so sync, active flag, position and colour describe the same pixel in the same cycle.

Every porch, sync width and visible size is a parameter. The defaults give the 640x480 timing: a line of 640 visible, 16 front-porch, 96 sync and 48 back-porch clocks, and a frame of 480 visible, 10 front-porch, 2 sync and 29 back-porch lines.

Top module: `vga_stripe_gen`

## Requirements
- R1: While rst_n is low the outputs are col=0, row=0, hsync_n=1, vsync_n=1, active=0 and rgb=0. The first clock edge after release presents pixel (0,0), and the frame offset restarts at 0.
- R2: col counts 0 to H_VIS+H_FP+H_SYNC+H_BP-1 and then wraps to 0. row advances by one on each wrap of col and itself wraps after V_VIS+V_FP+V_SYNC+V_BP-1.
- R3: hsync_n is 0 exactly for columns H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1, and is 1 for all other columns.
- R4: vsync_n is 0 exactly for rows V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1, and is 1 for all other rows.
- R5: active is 1 exactly when col < H_VIS and row < V_VIS.
- R6: rgb is 0 whenever active is 0.
- R7: On a visible pixel, rgb equals ((col + offset) mod 2^(8+STRIPE_SHIFT)) >> STRIPE_SHIFT. Each stripe is therefore 2^STRIPE_SHIFT pixels wide, and its 8-bit value is laid out as red[7:5], green[4:2], blue[1:0].
- R8: offset is 8+STRIPE_SHIFT bits wide and wraps. It increments once per frame, at the step from the last visible line to the first blanking line, so it applies from the next frame's first visible pixel.
- R9: col, row, hsync_n, vsync_n, active and rgb all describe the same pixel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High on visible pixels |
| col | output | $clog2(H_TOTAL) | Current column |
| row | output | $clog2(V_TOTAL) | Current row |
| rgb | output | 8 | Colour, red[7:5] green[4:2] blue[1:0] |

## Verification
The bench shrinks the raster to a 15-clock line (8 visible, 2 front porch, 3 sync, 2 back porch) and an 8-line frame (4 visible, 1 front porch, 2 sync, 1 back porch), with 2-pixel stripes. At this size one frame lasts 120 clocks. The bench can then run more than 512 frames, which carries the 9-bit offset through its wrap. Every column and row boundary, each sync edge and each porch edge is visited hundreds of times. A reset in the middle of a frame shows that the counters and the offset restart cleanly.

// File: rtl/vga_stripe_gen.sv
module vga_stripe_gen #(
  parameter int H_VIS        = 640,
  parameter int H_FP         = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BP         = 48,
  parameter int V_VIS        = 480,
  parameter int V_FP         = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BP         = 29,
  parameter int STRIPE_SHIFT = 4,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int CW      = $clog2(H_TOTAL),
  localparam int RW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          active,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [7:0]    rgb
);
  localparam int OW     = 8 + STRIPE_SHIFT;
  localparam int HS_BEG = H_VIS + H_FP;
  localparam int HS_END = HS_BEG + H_SYNC;
  localparam int VS_BEG = V_VIS + V_FP;
  localparam int VS_END = VS_BEG + V_SYNC;

  logic [CW-1:0] hc;
  logic [RW-1:0] vc;
  logic [OW-1:0] off;

  wire h_last = (hc == CW'(H_TOTAL - 1));
  wire v_last = (vc == RW'(V_TOTAL - 1));
  wire v_end_vis = (vc == RW'(V_VIS - 1));

  wire vis = (hc < CW'(H_VIS)) && (vc < RW'(V_VIS));
  wire hs  = (hc >= CW'(HS_BEG)) && (hc < CW'(HS_END));
  wire vs  = (vc >= RW'(VS_BEG)) && (vc < RW'(VS_END));
  wire [OW-1:0] sum = off + OW'(hc);
  wire [7:0] pix = vis ? sum[OW-1 -: 8] : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc  <= '0;
      vc  <= '0;
      off <= '0;
    end else begin
      hc <= h_last ? '0 : hc + 1'b1;
      if (h_last) begin
        vc <= v_last ? '0 : vc + 1'b1;
        if (v_end_vis) off <= off + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      active  <= 1'b0;
      col     <= '0;
      row     <= '0;
      rgb     <= 8'd0;
    end else begin
      hsync_n <= ~hs;
      vsync_n <= ~vs;
      active  <= vis;
      col     <= hc;
      row     <= vc;
      rgb     <= pix;
    end
  end

  p_col_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col == CW'(H_TOTAL - 1)) |=> (col == '0) && (row != $past(row)));

  p_hs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> (col == CW'(HS_BEG)));

  p_hs_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n && col != CW'(HS_END - 1)) |=> !hsync_n);

  p_vs_rows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> (row >= RW'(VS_BEG)) && (row < RW'(VS_END)));

  p_act_area_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (col < CW'(H_VIS)) && (row < RW'(V_VIS)));

  p_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (rgb == 8'd0));

  p_off_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (off != $past(off)) |-> (hc == '0) && (vc == RW'(V_VIS)));
endmodule

// File: tb/vga_stripe_gen_bench.sv
`timescale 1ns/1ps
module vga_stripe_gen_bench;
  localparam int HV = 8, HF = 2, HSY = 3, HB = 2;
  localparam int VV = 4, VF = 1, VSY = 2, VB = 1;
  localparam int SH = 1;
  localparam int HT = HV + HF + HSY + HB;
  localparam int VT = VV + VF + VSY + VB;
  localparam int CW = $clog2(HT);
  localparam int RW = $clog2(VT);
  localparam int OMOD = 1 << (8 + SH);
  localparam int FRAMES = 600;

  // probe table: col, row, hsync_n, vsync_n, active
  localparam int NPROBE = 8;
  localparam int PROBE [NPROBE][5] = '{
    '{7, 3, 1, 1, 1},
    '{8, 3, 1, 1, 0},
    '{9, 0, 1, 1, 0},
    '{10, 0, 0, 1, 0},
    '{12, 2, 0, 1, 0},
    '{13, 2, 1, 1, 0},
    '{0, 5, 1, 0, 0},
    '{14, 7, 1, 1, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n, vsync_n, active;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [7:0] rgb;

  int errors = 0;
  int checks = 0;
  int mh, mv, moff;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vga_stripe_gen #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HSY), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VSY), .V_BP(VB),
    .STRIPE_SHIFT(SH)
  ) u_vga_stripe_gen (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .active(active), .col(col), .row(row), .rgb(rgb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (model col=%0d row=%0d off=%0d)",
               tag, act, exp, mh, mv, moff);
    end
  endtask

  task automatic check_reset_state();
    chk("R1 col", int'(col), 0);
    chk("R1 row", int'(row), 0);
    chk("R1 hsync_n", int'(hsync_n), 1);
    chk("R1 vsync_n", int'(vsync_n), 1);
    chk("R1 active", int'(active), 0);
    chk("R1 rgb", int'(rgb), 0);
  endtask

  task automatic check_pixel();
    int vis, ehs, evs, ergb;
    vis  = (mh < HV && mv < VV) ? 1 : 0;
    ehs  = (mh >= HV + HF && mh < HV + HF + HSY) ? 0 : 1;
    evs  = (mv >= VV + VF && mv < VV + VF + VSY) ? 0 : 1;
    ergb = vis ? (((mh + moff) % OMOD) >> SH) : 0;
    chk("R2 col", int'(col), mh);
    chk("R2 row", int'(row), mv);
    chk("R3 hsync_n", int'(hsync_n), ehs);
    chk("R4 vsync_n", int'(vsync_n), evs);
    chk("R5 active", int'(active), vis);
    if (vis) chk("R7 rgb", int'(rgb), ergb);
    else     chk("R6 rgb", int'(rgb), 0);
    for (int p = 0; p < NPROBE; p++) begin
      if (PROBE[p][0] == mh && PROBE[p][1] == mv) begin
        chk("R9 probe hsync_n", int'(hsync_n), PROBE[p][2]);
        chk("R9 probe vsync_n", int'(vsync_n), PROBE[p][3]);
        chk("R9 probe active", int'(active), PROBE[p][4]);
      end
    end
  endtask

  task automatic advance_model();
    if (mh == HT - 1) begin
      mh = 0;
      if (mv == VV - 1) moff = (moff + 1) % OMOD;
      mv = (mv == VT - 1) ? 0 : mv + 1;
    end else begin
      mh = mh + 1;
    end
  endtask

  task automatic walk(input int cycles);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      check_pixel();
      advance_model();
    end
  endtask

  initial begin
    mh = 0; mv = 0; moff = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    // R8: 600 frames carry the 9-bit offset through its wrap
    walk(FRAMES * HT * VT);

    // R1: reset in mid-frame
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    mh = 0; mv = 0; moff = 0;
    walk(3 * HT * VT);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule